// File: doc/BRIEF.md
# Four-Channel KCS Mailbox

This block is a four-channel mailbox of the kind a management controller presents to a host processor in the Keyboard Controller Style. Every channel holds an input data word that the host writes and the management side reads. It also holds an output data word that the management side writes and the host reads, and a status word. Two flags in the status word track whether each data word is waiting to be consumed. The flags move only as side effects of accesses on the opposite sides, so the two agents can hand bytes back and forth without a shared lock.

The management side sees a flat, word-indexed 32-bit register space through a simple address, read and write bus. Read data is combinational, and a read's side effect takes place on the clock edge that ends the access. The host side has one narrow port: a channel select, a write strobe for input data, and a read strobe for output data. The selected channel's output data and status words are always visible on that port. Each channel can raise its own interrupt when the host leaves new input data. These interrupts are OR-ed with external subdevice interrupt levels into a single aggregate line.

Top module: `kcs_mailbox`

## Requirements
- R1: After reset every register reads zero, except the word at index 34 (byte offset 0x88), which reads the CFG7_INIT parameter. Management reads return register contents by word index.
- R2: Status word bit 0 is the output-full flag, bit 1 is the input-full flag and bit 3 is the command/data flag. A management write to a status word stores all of its bits.
- R3: A host write stores the value in the selected channel's input data word and sets that channel's input-full flag. The channel does not need to be enabled. Input data words are at indices 9, 10, 11 and 69 and status words at 15, 16, 17 and 71 for channels 1 to 4.
- R4: A host input write raises that channel's interrupt (irq_ch bit n-1 for channel n) on the next edge only when the channel is enabled and its interrupt enable is set. Enables: word 0 bits 5, 6 and 7 for channels 1 to 3, word 64 bit 0 for channel 4. Interrupt enables: word 2 bits 1, 2 and 3 for channels 1 to 3, word 64 bit 1 for channel 4.
- R5: A management read of an input data word returns its value. If the input-full flag was set, the read clears the flag and lowers that channel's interrupt.
- R6: A management write to an output data word (indices 12, 13, 14 and 70) stores it and sets the output-full flag. A host read of the output data word returns the value and clears the flag.
- R7: Channel 3 counts as enabled only when word 0 bit 7 and word 4 bit 2 are both set.
- R8: The aggregate interrupt is high while any channel interrupt is pending or any external interrupt input was high at the previous edge.
- R9: A management access to a word index of 72 or above writes nothing and reads zero.
- R10: When a host input write and a management read of the same input word share a cycle, the read returns the old value, the input-full flag ends set and the interrupt follows the write. When a management output write and a host output read share a cycle, the host gets the old value and the output-full flag ends set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m_addr | input | AW | Management word index |
| m_wr | input | 1 | Management write strobe |
| m_rd | input | 1 | Management read strobe (applies side effects) |
| m_wdata | input | 32 | Management write data |
| m_rdata | output | 32 | Management read data, combinational |
| h_ch | input | 2 | Host channel select, 0 to 3 for channels 1 to 4 |
| h_wr | input | 1 | Host write of input data |
| h_rd | input | 1 | Host read of output data (clears output-full) |
| h_wdata | input | 32 | Host write data |
| h_odr | output | 32 | Selected channel's output data word |
| h_status | output | 32 | Selected channel's status word |
| ext_irq | input | EXT_N | External subdevice interrupt levels |
| irq_ch | output | 4 | Per-channel input interrupts |
| irq | output | 1 | Aggregate interrupt |

## Verification
Two pairs of functions can collide on the same flag in one cycle. A host input write can meet a management read that clears the same input-full flag. A management output write can meet a host read that clears the output-full flag. The bench provokes each pair by asserting both strobes in a single cycle. It judges the outcome from the old value returned to the reader, from the flag seen afterwards and from the channel interrupt. The setter must win in both cases.

// File: rtl/kcs_mailbox.sv
module kcs_mailbox #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int NREGS = 72,
  parameter int EXT_N = 1,
  parameter logic [31:0] CFG7_INIT = 32'h0000_005A
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [AW-1:0]    m_addr,
  input  logic             m_wr,
  input  logic             m_rd,
  input  logic [DW-1:0]    m_wdata,
  output logic [DW-1:0]    m_rdata,
  input  logic [1:0]       h_ch,
  input  logic             h_wr,
  input  logic             h_rd,
  input  logic [DW-1:0]    h_wdata,
  output logic [DW-1:0]    h_odr,
  output logic [DW-1:0]    h_status,
  input  logic [EXT_N-1:0] ext_irq,
  output logic [3:0]       irq_ch,
  output logic             irq
);
  localparam int NCH = 4;
  localparam int IW = $clog2(NREGS);
  localparam int W_CTL0 = 0;
  localparam int W_IEN = 2;
  localparam int W_CTL4 = 4;
  localparam int W_CFG7 = 34;
  localparam int W_CH4 = 64;

  function automatic logic [IW-1:0] idr_w(int c);
    return (c == 3) ? IW'(69) : IW'(9 + c);
  endfunction
  function automatic logic [IW-1:0] odr_w(int c);
    return (c == 3) ? IW'(70) : IW'(12 + c);
  endfunction
  function automatic logic [IW-1:0] str_w(int c);
    return (c == 3) ? IW'(71) : IW'(15 + c);
  endfunction

  logic [DW-1:0] regs [NREGS];
  logic [NCH-1:0] pend_ch, pend_nxt, ch_en, ch_ie, ibf, rd_idr, wr_odr, hsel;
  logic [EXT_N-1:0] pend_ext;
  logic [DW-1:0] odr_v [NCH];
  logic [DW-1:0] str_v [NCH];
  logic in_rng;
  logic [IW-1:0] widx;

  assign in_rng = {{(32-AW){1'b0}}, m_addr} < 32'(NREGS);
  assign widx = m_addr[IW-1:0];
  assign m_rdata = in_rng ? regs[widx] : '0;

  assign ch_en[0] = regs[W_CTL0][5];
  assign ch_en[1] = regs[W_CTL0][6];
  assign ch_en[2] = regs[W_CTL0][7] & regs[W_CTL4][2];
  assign ch_en[3] = regs[W_CH4][0];
  assign ch_ie[0] = regs[W_IEN][1];
  assign ch_ie[1] = regs[W_IEN][2];
  assign ch_ie[2] = regs[W_IEN][3];
  assign ch_ie[3] = regs[W_CH4][1];

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    assign ibf[c]    = regs[str_w(c)][1];
    assign odr_v[c]  = regs[odr_w(c)];
    assign str_v[c]  = regs[str_w(c)];
    assign hsel[c]   = h_ch == 2'(c);
    assign rd_idr[c] = m_rd && in_rng && widx == idr_w(c);
    assign wr_odr[c] = m_wr && in_rng && widx == odr_w(c);
  end

  assign h_odr = odr_v[h_ch];
  assign h_status = str_v[h_ch];

  always_comb begin
    pend_nxt = pend_ch;
    for (int c = 0; c < NCH; c++) begin
      if (rd_idr[c] && ibf[c]) pend_nxt[c] = 1'b0;
      if (h_wr && hsel[c] && ch_en[c] && ch_ie[c]) pend_nxt[c] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= (i == W_CFG7) ? CFG7_INIT : '0;
      pend_ch <= '0;
      pend_ext <= '0;
    end else begin
      if (m_wr && in_rng) regs[widx] <= m_wdata;
      for (int c = 0; c < NCH; c++) begin
        if (h_rd && hsel[c]) regs[str_w(c)][0] <= 1'b0;
        if (wr_odr[c]) regs[str_w(c)][0] <= 1'b1;
        if (rd_idr[c] && ibf[c]) regs[str_w(c)][1] <= 1'b0;
        if (h_wr && hsel[c]) begin
          regs[idr_w(c)] <= h_wdata;
          regs[str_w(c)][1] <= 1'b1;
        end
      end
      pend_ch <= pend_nxt;
      pend_ext <= ext_irq;
    end
  end

  assign irq_ch = pend_ch;
  assign irq = |pend_ch | |pend_ext;
endmodule

// File: rtl/kcs_mailbox_chk.sv
module kcs_mailbox_chk #(
  parameter int AW = 8,
  parameter int EXT_N = 1,
  parameter int NREGS = 72
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    m_addr,
  input logic             m_wr,
  input logic             m_rd,
  input logic [31:0]      m_rdata,
  input logic [1:0]       h_ch,
  input logic             h_wr,
  input logic             h_rd,
  input logic [31:0]      h_status,
  input logic [EXT_N-1:0] ext_irq,
  input logic [3:0]       irq_ch,
  input logic             irq
);
  function automatic logic [AW-1:0] idr_a(int c);
    return (c == 3) ? AW'(69) : AW'(9 + c);
  endfunction

  assert_ibf_set_R3: assert property (@(posedge clk) disable iff (!rst_n)
    h_wr |=> (h_ch != $past(h_ch)) || h_status[1]);

  assert_obf_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wr && m_addr == AW'(12) && h_rd && h_ch == 2'd0) |=> (h_ch != 2'd0) || h_status[0]);

  assert_oor_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ({{(32-AW){1'b0}}, m_addr} >= 32'(NREGS)) |-> m_rdata == '0);

  assert_ext_agg_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(|ext_irq)) |-> irq);

  for (genvar c = 0; c < 4; c++) begin : g_a
    assert_irq_rise_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_ch[c]) |-> $past(h_wr) && $past(h_ch) == 2'(c));
    assert_irq_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_ch[c]) |-> $past(m_rd) && $past(m_addr) == idr_a(c));
  end
endmodule

bind kcs_mailbox kcs_mailbox_chk #(.AW(AW), .EXT_N(EXT_N), .NREGS(NREGS)) chk_i (
  .clk(clk), .rst_n(rst_n), .m_addr(m_addr), .m_wr(m_wr), .m_rd(m_rd),
  .m_rdata(m_rdata), .h_ch(h_ch), .h_wr(h_wr), .h_rd(h_rd),
  .h_status(h_status), .ext_irq(ext_irq), .irq_ch(irq_ch), .irq(irq)
);

// File: tb/kcs_mailbox_tb_top.sv
module kcs_mailbox_tb_top;
  localparam int AW = 8;
  logic clk = 0, rst_n = 0;
  logic [AW-1:0] m_addr = '0;
  logic m_wr = 0, m_rd = 0, h_wr = 0, h_rd = 0;
  logic [31:0] m_wdata = '0, h_wdata = '0, m_rdata, h_odr, h_status;
  logic [1:0] h_ch = '0;
  logic [0:0] ext_irq = '0;
  logic [3:0] irq_ch;
  logic irq;

  always #10 clk = ~clk;

  kcs_mailbox #(.AW(AW), .CFG7_INIT(32'h5A)) dut_i (.*);

  typedef enum int {S_MRD, S_HODR, S_HSTAT, S_IRQCH, S_IRQ} sel_t;
  typedef struct { sel_t sel; logic [31:0] exp; string req; } item_t;
  item_t q[$];
  event chk_ev;
  int n_chk = 0, n_err = 0;
  bit done = 0;

  always begin
    @(chk_ev);
    while (q.size() > 0) begin
      item_t it;
      logic [31:0] act;
      it = q.pop_front();
      case (it.sel)
        S_MRD:   act = m_rdata;
        S_HODR:  act = h_odr;
        S_HSTAT: act = h_status;
        S_IRQCH: act = {28'd0, irq_ch};
        default: act = {31'd0, irq};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_err++;
        $display("FAIL %s sel=%0d actual=%h expected=%h", it.req, it.sel, act, it.exp);
      end
    end
  end

  task automatic expect_v(sel_t s, logic [31:0] e, string r);
    item_t it;
    it.sel = s; it.exp = e; it.req = r;
    q.push_back(it);
    ->chk_ev;
    #1;
  endtask

  task automatic mwrite(int a, logic [31:0] d);
    @(negedge clk); m_addr = AW'(a); m_wdata = d; m_wr = 1;
    @(posedge clk); #1 m_wr = 0;
  endtask

  task automatic mread(int a, logic [31:0] e, string r);
    @(negedge clk); m_addr = AW'(a); m_rd = 1;
    #1 expect_v(S_MRD, e, r);
    @(posedge clk); #1 m_rd = 0;
  endtask

  task automatic hwrite(int c, logic [31:0] d);
    @(negedge clk); h_ch = 2'(c); h_wdata = d; h_wr = 1;
    @(posedge clk); #1 h_wr = 0;
  endtask

  task automatic hread(int c, logic [31:0] e, string r);
    @(negedge clk); h_ch = 2'(c); h_rd = 1;
    #1 expect_v(S_HODR, e, r);
    @(posedge clk); #1 h_rd = 0;
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    // R1 reset state
    mread(0, 0, "R1");
    mread(34, 32'h5A, "R1");
    mread(15, 0, "R1");
    expect_v(S_IRQ, 0, "R1");
    // R3 disabled channel still sets IBF, no interrupt
    hwrite(0, 32'h11);
    mread(15, 32'h2, "R3");
    expect_v(S_IRQCH, 0, "R4");
    mread(9, 32'h11, "R5");
    mread(15, 0, "R5");
    // R4 enabled channel 1
    mwrite(0, 32'h20);
    mwrite(2, 32'h2);
    hwrite(0, 32'h22);
    expect_v(S_IRQCH, 4'b0001, "R4");
    expect_v(S_IRQ, 1, "R8");
    mread(9, 32'h22, "R5");
    expect_v(S_IRQCH, 0, "R5");
    expect_v(S_IRQ, 0, "R8");
    // R4 channel 4 through word 64
    mwrite(64, 32'h3);
    hwrite(3, 32'h44);
    expect_v(S_IRQCH, 4'b1000, "R4");
    mread(69, 32'h44, "R5");
    expect_v(S_IRQCH, 0, "R5");
    // R7 channel 3 needs both bits
    mwrite(2, 32'hE);
    mwrite(0, 32'hE0);
    hwrite(2, 32'h33);
    expect_v(S_IRQCH, 0, "R7");
    mread(11, 32'h33, "R7");
    mwrite(4, 32'h4);
    hwrite(2, 32'h34);
    expect_v(S_IRQCH, 4'b0100, "R7");
    mread(11, 32'h34, "R5");
    expect_v(S_IRQ, 0, "R5");
    // R6 output path
    mwrite(12, 32'hAB);
    @(negedge clk); h_ch = 0; #1 expect_v(S_HSTAT, 32'h1, "R6");
    hread(0, 32'hAB, "R6");
    expect_v(S_HSTAT, 0, "R6");
    // R2 command/data bit and field positions
    mwrite(16, 32'h8);
    mread(16, 32'h8, "R2");
    mwrite(13, 32'h5);
    mread(16, 32'h9, "R2");
    // R9 out of range
    mwrite(100, 32'hFFFF_FFFF);
    mread(100, 0, "R9");
    mread(0, 32'hE0, "R9");
    // R8 external level
    @(negedge clk); ext_irq = 1;
    @(posedge clk); #1 expect_v(S_IRQ, 1, "R8");
    expect_v(S_IRQCH, 0, "R8");
    @(negedge clk); ext_irq = 0;
    @(posedge clk); #1 expect_v(S_IRQ, 0, "R8");
    // R10 input collision on channel 2
    hwrite(1, 32'h55);
    @(negedge clk); h_ch = 1; h_wdata = 32'h66; h_wr = 1; m_addr = 10; m_rd = 1;
    #1 expect_v(S_MRD, 32'h55, "R10");
    @(posedge clk); #1 h_wr = 0; m_rd = 0;
    expect_v(S_IRQCH, 4'b0010, "R10");
    mread(16, 32'hB, "R10");
    mread(10, 32'h66, "R10");
    expect_v(S_IRQCH, 0, "R10");
    // R10 output collision on channel 1
    @(negedge clk); h_ch = 0; h_rd = 1; m_addr = 12; m_wdata = 32'hCD; m_wr = 1;
    #1 expect_v(S_HODR, 32'hAB, "R10");
    @(posedge clk); #1 h_rd = 0; m_wr = 0;
    expect_v(S_HSTAT, 32'h1, "R10");
    hread(0, 32'hCD, "R6");
    done = 1;
    #5;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule